// File: doc/BRIEF.md
# Luma Quarter-Sample Interpolator (horizontal quarter, vertical half)

This block forms motion-compensated luma prediction samples for the two fractional positions that sit half a sample down and a quarter or three quarters of a sample across. A caller pulses `start` with the block width, height and fractional x offset. It then streams the reference window in raster order. The window covers `W+5` columns by `H+5` rows and starts two rows above and two columns left of the block origin. The block returns the `W*H` predicted 8-bit samples in raster order.

Each new reference row is combined with five stored rows to run a six-tap vertical filter, with taps 1, -5, 20, 20, -5, 1. The vertical results are kept at full precision. A second six-tap pass runs across six adjacent vertical results to form the centre half-sample. One of those same vertical results, rounded on its own, gives the side half-sample. The output is the upward-rounding average of the two.

Both streams use valid/ready handshakes. Output backpressure stalls input acceptance, so no sample is lost.

Top module: `lumaq_interp`

## Requirements
- R1: After reset, `out_valid`, `done`, `busy` and `in_ready` are all 0.
- R2: The centre value for output (x,y) is computed from the vertical intermediates V(y,x+k), where V(y,c) = (a0+a5) + 20*(a2+a3) - 5*(a1+a4) over the window samples of column c at rows y..y+5. The vertical intermediates are not rounded. The centre is (sum + 512) >> 10 over those six intermediates with the same taps, clipped to 0..255.
- R3: The side value is V(y,x+2) when offset bit 1 is 0 and V(y,x+3) when it is 1. It is rounded as (V + 16) >> 5 and clipped to 0..255.
- R4: Each output sample is (centre + side + 1) >> 1.
- R5: Bit 0 of `cfg_frac` has no effect on the output. Offsets 0 and 1 give the same result, and so do offsets 2 and 3.
- R6: Exactly `W*H` outputs leave in raster order. The first output comes only after the sixth sample of the sixth window row has been accepted.
- R7: Widths 4, 8 and 16 and even heights from 2 to `MAX_H` are supported. `cfg_width` and `cfg_height` carry the plain values.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R9: `done` is high for exactly one cycle, on the cycle after the last output is accepted. `busy` falls in the same cycle.
- R10: While idle, `in_ready` is 0. A `start` pulse during a block is ignored, and the latched configuration is kept.
- R11: Values below 0 clip to 0 and values above 255 clip to 255, both for the centre and for the side value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a block; latches configuration when idle |
| cfg_width | input | 5 | Block width (4, 8 or 16) |
| cfg_height | input | 5 | Block height (even, 2..MAX_H) |
| cfg_frac | input | 2 | Fractional x offset; bit 1 picks the side column |
| busy | output | 1 | Block in progress |
| in_valid | input | 1 | Reference sample valid |
| in_ready | output | 1 | Reference sample accepted this cycle when valid |
| in_data | input | 8 | Reference sample, raster order over the window |
| out_valid | output | 1 | Predicted sample valid |
| out_ready | input | 1 | Downstream accepts the predicted sample |
| out_data | output | 8 | Predicted sample |
| done | output | 1 | One-cycle pulse after the last output is accepted |

## Verification
The bench builds the block with its default `MAX_W = 16` and `MAX_H = 16`. This lets it run every supported width, including a full 16x16 block, whose 21-column window fills the whole line buffer. It uses ramps, pseudo-random values and 0/255 row and column bands. The bands drive the vertical and horizontal sums past both ends of the 8-bit range. Some runs apply pseudo-random output backpressure, and one run pulses `start` partway through a block.

// File: rtl/lumaq_pkg.sv
// Shared constants and arithmetic for the luma quarter-sample interpolator.
// Assumes 8-bit samples and the six-tap kernel 1,-5,20,20,-5,1.
package lumaq_pkg;
    localparam int PIX_W = 8;
    localparam int MID_W = 16;
    localparam int ACC_W = 32;
    localparam int TAPS  = 6;

    // Six-tap kernel on signed operands, evaluated as paired sums.
    function automatic logic signed [ACC_W-1:0] six_tap(
        input logic signed [ACC_W-1:0] a, b, c, d, e, f);
        return (a + f) + 32'sd20 * (c + d) - 32'sd5 * (b + e);
    endfunction

    // Round-to-nearest right shift followed by clipping to the pixel range.
    function automatic logic [PIX_W-1:0] round_clip(
        input logic signed [ACC_W-1:0] x, input int sh);
        logic signed [ACC_W-1:0] r;
        r = (x + (32'sd1 <<< (sh - 1))) >>> sh;
        if (r < 0)
            return '0;
        else if (r > 32'sd255)
            return '1;
        else
            return PIX_W'(r);
    endfunction
endpackage

// File: rtl/lumaq_vcol.sv
// Column history and vertical six-tap filter.
// Keeps the last TAPS-1 samples of every window column. When a new sample
// arrives for a column, it forms the unrounded vertical intermediate from the
// history and the new sample. Assumes col < COLS.
module lumaq_vcol
    import lumaq_pkg::*;
#(
    parameter int COLS = 21
) (
    input  logic                    clk,
    input  logic                    shift_en,
    input  logic [$clog2(COLS)-1:0] col,
    input  logic [PIX_W-1:0]        pix_in,
    output logic signed [MID_W-1:0] v_out
);
    localparam int DEPTH = TAPS - 1;

    logic [PIX_W-1:0]        hist [DEPTH][COLS];
    logic signed [ACC_W-1:0] s    [TAPS];
    logic signed [ACC_W-1:0] acc;

    // Zero-extend the stored column samples into the tap operands.
    for (genvar k = 0; k < DEPTH; k++) begin : g_tap
        assign s[k] = $signed({{(ACC_W-PIX_W){1'b0}}, hist[k][col]});
    end
    assign s[TAPS-1] = $signed({{(ACC_W-PIX_W){1'b0}}, pix_in});

    // Vertical filter; the value fits in MID_W bits, so no clipping is applied.
    always_comb begin
        acc   = six_tap(s[0], s[1], s[2], s[3], s[4], s[5]);
        v_out = MID_W'(acc);
    end

    // Push the new sample into this column's history, dropping the oldest.
    always_ff @(posedge clk) begin
        if (shift_en) begin
            for (int k = 0; k < DEPTH - 1; k++)
                hist[k][col] <= hist[k+1][col];
            hist[DEPTH-1][col] <= pix_in;
        end
    end
endmodule

// File: rtl/lumaq_hpass.sv
// Horizontal six-tap pass over the vertical intermediates, side half-sample
// pick and rounding average. Holds the previous TAPS-1 intermediates of the
// current row. The newest one arrives on v_in. Output is valid whenever the
// window is fully populated.
module lumaq_hpass
    import lumaq_pkg::*;
(
    input  logic                    clk,
    input  logic                    shift_en,
    input  logic signed [MID_W-1:0] v_in,
    input  logic                    side_hi,
    output logic [PIX_W-1:0]        pix_out
);
    localparam int DEPTH  = TAPS - 1;
    localparam int SIDE_L = TAPS / 2 - 1;

    logic signed [MID_W-1:0] win [DEPTH];
    logic signed [ACC_W-1:0] h   [TAPS];
    logic [PIX_W-1:0]        centre, side;
    logic [PIX_W:0]          sum;

    // Sign-extend the held intermediates into the horizontal operands.
    for (genvar k = 0; k < DEPTH; k++) begin : g_op
        assign h[k] = ACC_W'(win[k]);
    end
    assign h[TAPS-1] = ACC_W'(v_in);

    // Centre from both passes, side from one intermediate, then average upward.
    always_comb begin
        centre  = round_clip(six_tap(h[0], h[1], h[2], h[3], h[4], h[5]), 10);
        side    = round_clip(side_hi ? h[SIDE_L+1] : h[SIDE_L], 5);
        sum     = {1'b0, centre} + {1'b0, side} + 1'b1;
        pix_out = sum[PIX_W:1];
    end

    // Slide the horizontal window by one intermediate per accepted sample.
    always_ff @(posedge clk) begin
        if (shift_en) begin
            for (int k = 0; k < DEPTH - 1; k++)
                win[k] <= win[k+1];
            win[DEPTH-1] <= v_in;
        end
    end
endmodule

// File: rtl/lumaq_interp.sv
// Luma interpolator for the (1/4,1/2) and (3/4,1/2) positions.
// Accepts the (W+5)x(H+5) reference window in raster order after a start
// pulse. Emits W*H predicted samples in raster order through a single output
// register. Assumes W in {4,8,16} and H even, 2..MAX_H.
module lumaq_interp
    import lumaq_pkg::*;
#(
    parameter int MAX_W = 16,
    parameter int MAX_H = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [$clog2(MAX_W+1)-1:0]   cfg_width,
    input  logic [$clog2(MAX_H+1)-1:0]   cfg_height,
    input  logic [1:0]                   cfg_frac,
    output logic                         busy,
    input  logic                         in_valid,
    output logic                         in_ready,
    input  logic [PIX_W-1:0]             in_data,
    output logic                         out_valid,
    input  logic                         out_ready,
    output logic [PIX_W-1:0]             out_data,
    output logic                         done
);
    localparam int EDGE = TAPS - 1;
    localparam int COLS = MAX_W + EDGE;
    localparam int CW   = $clog2(COLS);
    localparam int RW   = $clog2(MAX_H + TAPS);
    localparam int WW   = $clog2(MAX_W + 1);
    localparam int HW   = $clog2(MAX_H + 1);

    logic [WW-1:0]    wid_q;
    logic [HW-1:0]    hgt_q;
    logic [1:0]       frac_q;
    logic             busy_q, out_valid_q, out_last_q, done_q;
    logic [CW-1:0]    col_q;
    logic [RW-1:0]    row_q;
    logic [PIX_W-1:0] out_data_q, pix_next;
    logic signed [MID_W-1:0] v_mid;
    logic             in_fire, out_fire, produce, row_end, last_in, rows_left;

    assign row_end   = (col_q == CW'(wid_q) + CW'(EDGE - 1));
    assign last_in   = row_end && (row_q == RW'(hgt_q) + RW'(EDGE - 1));
    assign rows_left = (row_q < RW'(hgt_q) + RW'(EDGE));
    assign in_ready  = busy_q && rows_left && (!out_valid_q || out_ready);
    assign in_fire   = in_valid && in_ready;
    assign out_fire  = out_valid_q && out_ready;
    assign produce   = in_fire && (row_q >= RW'(EDGE)) && (col_q >= CW'(EDGE));

    lumaq_vcol #(.COLS(COLS)) u_vcol (
        .clk      (clk),
        .shift_en (in_fire),
        .col      (col_q),
        .pix_in   (in_data),
        .v_out    (v_mid)
    );

    lumaq_hpass u_hpass (
        .clk      (clk),
        .shift_en (in_fire),
        .v_in     (v_mid),
        .side_hi  (frac_q[1]),
        .pix_out  (pix_next)
    );

    // Configuration latch and block-level busy/done control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            wid_q  <= '0;
            hgt_q  <= '0;
            frac_q <= '0;
        end else begin
            done_q <= out_fire && out_last_q;
            if (out_fire && out_last_q) begin
                busy_q <= 1'b0;
            end else if (start && !busy_q) begin
                busy_q <= 1'b1;
                wid_q  <= cfg_width;
                hgt_q  <= cfg_height;
                frac_q <= cfg_frac;
            end
        end
    end

    // Window position counters, advanced per accepted reference sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
            row_q <= '0;
        end else if (start && !busy_q) begin
            col_q <= '0;
            row_q <= '0;
        end else if (in_fire) begin
            col_q <= row_end ? '0 : col_q + 1'b1;
            row_q <= row_end ? row_q + 1'b1 : row_q;
        end
    end

    // Output register: load on a completed window, clear when taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_q <= 1'b0;
            out_last_q  <= 1'b0;
            out_data_q  <= '0;
        end else if (produce) begin
            out_valid_q <= 1'b1;
            out_last_q  <= last_in;
            out_data_q  <= pix_next;
        end else if (out_ready) begin
            out_valid_q <= 1'b0;
        end
    end

    assign busy      = busy_q;
    assign out_valid = out_valid_q;
    assign out_data  = out_data_q;
    assign done      = done_q;

    // R8: a stalled output is held unchanged.
    p_hold_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_q && !out_ready) |=> (out_valid_q && $stable(out_data_q)));

    // R9: done lasts a single cycle.
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R9: the block is idle when done is raised.
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy_q);

    // R10: a start seen while busy leaves the configuration untouched.
    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && start) |=> ($stable(wid_q) && $stable(hgt_q) && $stable(frac_q)));

    // R6: the first output of a window cannot appear before six rows are in.
    p_late_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid_q) |-> ($past(row_q) >= RW'(EDGE)));
endmodule

// File: tb/lumaq_interp_tb.sv
module lumaq_interp_tb;
    localparam int MAX_W = 16;
    localparam int MAX_H = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [4:0] cfg_width = '0;
    logic [4:0] cfg_height = '0;
    logic [1:0] cfg_frac = '0;
    logic       busy, in_ready, out_valid, done;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       out_ready = 1'b1;
    logic [7:0] out_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int bp_mode = 0;
    int expq[$];
    int refwin [MAX_H+5][MAX_W+5];
    logic [15:0] lfsr = 16'hACE1;
    logic prev_stall = 1'b0;
    logic [7:0] prev_data = '0;

    always #4 clk = ~clk;

    lumaq_interp #(.MAX_W(MAX_W), .MAX_H(MAX_H)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_width(cfg_width),
        .cfg_height(cfg_height), .cfg_frac(cfg_frac), .busy(busy),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int clip8(input int x);
        return (x < 0) ? 0 : ((x > 255) ? 255 : x);
    endfunction

    function automatic int tap6(input int a, b, c, d, e, f);
        return (a + f) + 20 * (c + d) - 5 * (b + e);
    endfunction

    function automatic int vmid(input int r, input int c);
        return tap6(refwin[r][c], refwin[r+1][c], refwin[r+2][c],
                    refwin[r+3][c], refwin[r+4][c], refwin[r+5][c]);
    endfunction

    function automatic int pattern(input int pat, input int r, input int c);
        case (pat)
            0: return (r * 7 + c * 13 + 5) & 255;
            1: return (r * r * 31 + c * 57 + r * c * 11 + 3) & 255;
            2: return (((r % 6) >> 1) == 1) ? 255 : 0;
            default: return (((c % 6) >> 1) == 1) ? 255 : 0;
        endcase
    endfunction

    // Output-side backpressure generator, updated away from both edges.
    always begin
        @(posedge clk);
        #2;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = (bp_mode == 0) ? 1'b1 : (lfsr[0] | lfsr[3]);
    end

    // Monitor: scoreboard compare on every output handshake (R2, R3, R4, R8).
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) begin
                chk(out_valid == 1'b1, "R8 valid held", int'(out_valid), 1);
                chk(out_data == prev_data, "R8 data held", int'(out_data), int'(prev_data));
            end
            if (out_valid && out_ready) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R6 extra output", int'(out_data), -1);
                end else begin
                    int e;
                    e = expq.pop_front();
                    chk(int'(out_data) == e, "R2/R3/R4 sample", int'(out_data), e);
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL R9 watchdog: actual %0d expected %0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic send(input int d);
        bit acc;
        in_valid = 1'b1;
        in_data  = 8'(d);
        do begin
            acc = in_ready;
            @(negedge clk);
        end while (!acc);
        in_valid = 1'b0;
    endtask

    task automatic run_block(input int w, input int h, input int frac,
                             input int pat, input int bp, input bit poke);
        int t;
        for (int r = 0; r < h + 5; r++)
            for (int c = 0; c < w + 5; c++)
                refwin[r][c] = pattern(pat, r, c);
        for (int y = 0; y < h; y++) begin
            for (int x = 0; x < w; x++) begin
                int cen, side;
                cen  = clip8((tap6(vmid(y, x), vmid(y, x+1), vmid(y, x+2),
                                   vmid(y, x+3), vmid(y, x+4), vmid(y, x+5)) + 512) >>> 10);
                side = clip8((vmid(y, x + 2 + ((frac >> 1) & 1)) + 16) >>> 5);
                expq.push_back((cen + side + 1) >> 1);
            end
        end
        bp_mode    = bp;
        cfg_width  = 5'(w);
        cfg_height = 5'(h);
        cfg_frac   = 2'(frac);
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R7 busy after start", int'(busy), 1);
        for (int r = 0; r < h + 5; r++) begin
            for (int c = 0; c < w + 5; c++) begin
                if (poke && r == 2 && c == 0) begin
                    start     = 1'b1;
                    cfg_width = (w == 4) ? 5'd8 : 5'd4;
                    cfg_frac  = ~cfg_frac;
                end
                send(refwin[r][c]);
                start = 1'b0;
            end
        end
        t = 0;
        while (!done && t < 5000) begin
            @(negedge clk);
            t++;
        end
        chk(done == 1'b1, "R9 done seen", int'(done), 1);
        chk(expq.size() == 0, "R6 all outputs delivered", expq.size(), 0);
        chk(busy == 1'b0, "R9 busy falls with done", int'(busy), 0);
        @(negedge clk);
        chk(done == 1'b0, "R9 done one cycle", int'(done), 0);
        chk(in_ready == 1'b0, "R10 idle in_ready", int'(in_ready), 0);
        expq.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(in_ready == 1'b0, "R1 in_ready", int'(in_ready), 0);
        run_block(4, 2, 1, 0, 0, 1'b0);   // R2 R3 R4 smallest block, left side column
        run_block(8, 4, 3, 1, 1, 1'b0);   // R3 right side column under backpressure R8
        run_block(16, 2, 2, 0, 1, 1'b0);  // R5 offset 2 behaves as 3, R7 width 16
        run_block(4, 4, 1, 2, 0, 1'b0);   // R11 row bands push vertical sums past both ends
        run_block(8, 2, 3, 3, 1, 1'b0);   // R11 column bands push horizontal sums past both ends
        run_block(16, 16, 3, 1, 1, 1'b1); // R7 full size, R10 start ignored mid-block
        run_block(4, 6, 0, 3, 0, 1'b0);   // R5 offset 0 behaves as 1
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule